// File: doc/BRIEF.md
# Time-Redundant Re-Execution Checker

This unit sits at the execute end of a small in-order integer pipeline. It catches transient faults by producing every ALU result twice before the result is allowed to commit. The ALU is split into two independent units. The arithmetic unit handles add, subtract and the two less-than compares. The logical unit handles AND, OR, XOR and NOR. Each instruction runs once in its own unit when it is accepted, then moves into a chain of four holding stages, one stage per clock. In any cycle where a unit is not needed by the instruction being accepted (including cycles with no instruction at all), that unit re-executes the oldest held instruction of its class that still lacks a second result. The re-executions may therefore happen out of program order. Commits always happen in program order.

When an instruction leaves the last holding stage, its two results are compared. Any difference is reported as a soft error. A difference between the two redundant copies of the operation code is also reported as a soft error. In either case the instruction produces no committed result. If an instruction reaches the last holding stage still holding only one result, intake pauses for that cycle. Both units are then free, and the instruction is re-executed in its own unit before the compare. Two XOR mask inputs let a fault be forced onto either unit's output.

Top module: `rexec_checker`

## Requirements
- R1: After reset, all holding stages are empty: `out_valid` and `out_err` are low and `in_ready` is high.
- R2: With operation bit 2 = 0 the arithmetic unit computes, by bits [1:0]: 0 = a+b, 1 = a-b, 2 = signed a<b (1 or 0), 3 = unsigned a<b (1 or 0).
- R3: With operation bit 2 = 1 the logical unit computes, by bits [1:0]: 0 = a AND b, 1 = a OR b, 2 = a XOR b, 3 = NOR of a and b.
- R4: An instruction accepted on a rising edge (`in_valid` and `in_ready` high) shows its outcome on the fourth rising edge after that one, in acceptance order, with no instruction lost or duplicated.
- R5: Every instruction gets a second result from a unit left free by the execute stage, with the oldest waiting instruction served first. A stream that alternates arithmetic and logical operations never lowers `in_ready`.
- R6: When the oldest held instruction reaches the last stage with one result, `in_ready` is low for that cycle and the instruction is re-executed in its own unit. A back-to-back stream of one class therefore pauses intake but still commits correct results.
- R7: If the two results differ (for example because a fault mask bit was set during either execution), `out_err` is high for one cycle, `out_valid` stays low and `out_result` is zero for that instruction only.
- R8: If the two operation-code copies differ on acceptance, the instruction ends exactly as in R7.
- R9: `out_valid` and `out_err` are never high together, and `out_result` is zero whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | Intake open this cycle |
| in_op_a | input | 3 | Operation code from first decoder: bit 2 unit, bits [1:0] function |
| in_op_b | input | 3 | Operation code from second decoder |
| in_src1 | input | 32 | First operand |
| in_src2 | input | 32 | Second operand |
| flt_arith | input | 32 | XOR mask forced onto the arithmetic unit output |
| flt_logic | input | 32 | XOR mask forced onto the logical unit output |
| out_valid | output | 1 | A checked result commits |
| out_result | output | 32 | Committed result, zero when not valid |
| out_err | output | 1 | Soft error detected for the retiring instruction |

## Verification
The assertions take for granted that an offered instruction's operands and operation codes stay steady until it is accepted. They also assume the fault masks are nonzero only during the single cycle meant for the fault, so that a bit flip reaches exactly one execution. The bench presents each instruction at a falling edge and holds it until `in_ready` is seen high. It applies a mask only in the cycle where the instruction is being accepted, which is when that unit's output goes to the new instruction alone. The masks are cleared at the next falling edge.

// File: rtl/rexec_pkg.sv
// Shared widths and the record carried through the holding stages.
// Assumes a 32-bit datapath and a 3-bit operation code (unit bit plus
// a 2-bit function select).
package rexec_pkg;
    localparam int XLEN   = 32;
    localparam int FNW    = 2;
    localparam int OPW    = FNW + 1;
    localparam int NUNITS = 2;

    localparam logic UNIT_ARITH = 1'b0;
    localparam logic UNIT_LOGIC = 1'b1;

    typedef enum logic [FNW-1:0] {
        AF_ADD  = 2'd0,
        AF_SUB  = 2'd1,
        AF_SLT  = 2'd2,
        AF_SLTU = 2'd3
    } arith_fn_e;

    typedef enum logic [FNW-1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOR = 2'd3
    } logic_fn_e;

    // One held instruction: operands, first result, and check state.
    typedef struct packed {
        logic            vld;
        logic            unit;
        logic [FNW-1:0]  fn;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
        logic            dbl;   // second result already obtained
        logic            bad;   // mismatch seen (results or decoders)
    } slot_t;
endpackage

// File: rtl/rexec_arith_unit.sv
// Arithmetic functional unit: add, subtract, signed and unsigned less-than.
// Purely combinational; the function select follows rexec_pkg::arith_fn_e.
module rexec_arith_unit
    import rexec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [FNW-1:0] fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    // Select the arithmetic result for the requested function.
    always_comb begin
        unique case (arith_fn_e'(fn))
            AF_ADD:  y = a + b;
            AF_SUB:  y = a - b;
            AF_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            AF_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rexec_logic_unit.sv
// Logical functional unit: AND, OR, XOR, NOR. Purely combinational; the
// function select follows rexec_pkg::logic_fn_e.
module rexec_logic_unit
    import rexec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [FNW-1:0] fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    // Select the bitwise result for the requested function.
    always_comb begin
        unique case (logic_fn_e'(fn))
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            LF_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rexec_pick.sv
// Oldest-first picker: grants the highest-index requester (index N-1 is
// the deepest holding stage). Grant is suppressed when the unit is busy.
module rexec_pick #(
    parameter int N = 4
) (
    input  logic         busy,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Scan from the youngest upward so the deepest request wins.
    always_comb begin
        gnt = '0;
        if (!busy) begin
            for (int k = 0; k < N; k++) begin
                if (req[k]) begin
                    gnt    = '0;
                    gnt[k] = 1'b1;
                end
            end
        end
        any = |gnt;
    end
endmodule

// File: rtl/rexec_checker.sv
// Time-redundant re-execution checker. An accepted instruction executes in
// its own unit, then passes DEPTH holding stages. Units left free by the
// execute stage re-execute the oldest held instruction of their class. At
// the last stage both results are compared and the outcome is registered.
// Assumes the offered instruction stays steady while in_ready is low.
module rexec_checker
    import rexec_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OPW-1:0]   in_op_a,
    input  logic [OPW-1:0]   in_op_b,
    input  logic [XLEN-1:0]  in_src1,
    input  logic [XLEN-1:0]  in_src2,
    input  logic [XLEN-1:0]  flt_arith,
    input  logic [XLEN-1:0]  flt_logic,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_err
);
    localparam int LAST = DEPTH - 1;

    slot_t            stg_q   [DEPTH];
    slot_t            stg_upd [DEPTH];
    slot_t            entry;
    logic             exec_go;
    logic             exec_unit;
    logic             tail_single;
    logic             tail_grant;
    logic [DEPTH-1:0] req   [NUNITS];
    logic [DEPTH-1:0] gnt   [NUNITS];
    logic [NUNITS-1:0] busy;
    logic [NUNITS-1:0] served;
    logic [XLEN-1:0]  uy    [NUNITS];

    // Intake pauses while the deepest instruction still lacks its second result.
    always_comb begin
        tail_single = stg_q[LAST].vld && !stg_q[LAST].dbl;
        in_ready    = !tail_single;
        exec_go     = in_valid && in_ready;
        exec_unit   = in_op_a[OPW-1];
    end

    // One functional unit per class, each with its own picker and operand mux.
    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        logic [FNW-1:0]  u_fn;
        logic [XLEN-1:0] u_a;
        logic [XLEN-1:0] u_b;
        logic [XLEN-1:0] u_raw;
        logic            u_any;

        // Held instructions of this class that still need a second result.
        always_comb begin
            for (int k = 0; k < DEPTH; k++) begin
                req[u][k] = stg_q[k].vld && !stg_q[k].dbl && (stg_q[k].unit == u[0]);
            end
            busy[u] = exec_go && (exec_unit == u[0]);
        end

        rexec_pick #(.N(DEPTH)) i_pick (
            .busy (busy[u]),
            .req  (req[u]),
            .gnt  (gnt[u]),
            .any  (u_any)
        );

        // Feed the unit from the execute stage or from the granted stage.
        always_comb begin
            u_fn = in_op_a[FNW-1:0];
            u_a  = in_src1;
            u_b  = in_src2;
            if (!busy[u]) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (gnt[u][k]) begin
                        u_fn = stg_q[k].fn;
                        u_a  = stg_q[k].opa;
                        u_b  = stg_q[k].opb;
                    end
                end
            end
        end

        if (u == 0) begin : g_arith
            rexec_arith_unit #(.W(XLEN)) i_fu (
                .fn (u_fn),
                .a  (u_a),
                .b  (u_b),
                .y  (u_raw)
            );
        end else begin : g_logic
            rexec_logic_unit #(.W(XLEN)) i_fu (
                .fn (u_fn),
                .a  (u_a),
                .b  (u_b),
                .y  (u_raw)
            );
        end

        // Apply the fault mask of this unit to its output.
        always_comb begin
            uy[u]     = u_raw ^ ((u == 0) ? flt_arith : flt_logic);
            served[u] = u_any;
        end
    end

    // Fold each granted re-execution into its stage record.
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            stg_upd[k] = stg_q[k];
            if (gnt[stg_q[k].unit][k]) begin
                stg_upd[k].dbl = 1'b1;
                stg_upd[k].bad = stg_q[k].bad || (uy[stg_q[k].unit] != stg_q[k].res);
            end
        end
        tail_grant = gnt[stg_q[LAST].unit][LAST];
    end

    // Record for the instruction executing this cycle.
    always_comb begin
        entry      = '0;
        entry.vld  = exec_go;
        entry.unit = exec_unit;
        entry.fn   = in_op_a[FNW-1:0];
        entry.opa  = in_src1;
        entry.opb  = in_src2;
        entry.res  = uy[exec_unit];
        entry.dbl  = 1'b0;
        entry.bad  = (in_op_a != in_op_b);
    end

    // Advance the holding stages one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stg_q[k] <= '0;
            end
        end else begin
            stg_q[0] <= entry;
            for (int k = 1; k < DEPTH; k++) begin
                stg_q[k] <= stg_upd[k-1];
            end
        end
    end

    // Register the commit outcome of the retiring instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= stg_upd[LAST].vld && stg_upd[LAST].dbl && !stg_upd[LAST].bad;
            out_err    <= stg_upd[LAST].vld && (stg_upd[LAST].bad || !stg_upd[LAST].dbl);
            out_result <= (stg_upd[LAST].vld && stg_upd[LAST].dbl && !stg_upd[LAST].bad)
                          ? stg_upd[LAST].res : '0;
        end
    end
endmodule

// File: rtl/rexec_checker_sva.sv
// Checker for rexec_checker: relates the retiring stage to the registered
// outputs and the stall condition to the unit grants.
module rexec_checker_sva #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_err,
    input logic [W-1:0] out_result,
    input logic         tail_vld,
    input logic         tail_single,
    input logic         tail_grant
);
    // R9
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));

    // R9
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == '0));

    // R4
    retire_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_vld |=> (out_valid || out_err));

    // R4
    retire_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tail_vld |=> !(out_valid || out_err));

    // R6
    tail_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_single |-> tail_grant);

    // R6
    stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> tail_vld);
endmodule

bind rexec_checker rexec_checker_sva #(.W(rexec_pkg::XLEN)) i_rexec_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_err     (out_err),
    .out_result  (out_result),
    .tail_vld    (stg_q[DEPTH-1].vld),
    .tail_single (tail_single),
    .tail_grant  (tail_grant)
);

// File: tb/test_rexec_checker.sv
// Directed bench: each task drives one scenario and checks its commits
// against an in-order scoreboard filled from an independent model.
module test_rexec_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op_a = '0;
    logic [2:0]  in_op_b = '0;
    logic [31:0] in_src1 = '0;
    logic [31:0] in_src2 = '0;
    logic [31:0] flt_arith = '0;
    logic [31:0] flt_logic = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int stalls = 0;
    bit finished = 0;

    logic [31:0] sb_res [64];
    bit          sb_err [64];
    int          sb_cyc [64];
    int          sb_tag [64];
    int          head = 0;
    int          tail = 0;

    rexec_checker i_rexec_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_op_a    (in_op_a),
        .in_op_b    (in_op_b),
        .in_src1    (in_src1),
        .in_src2    (in_src2),
        .flt_arith  (flt_arith),
        .flt_logic  (flt_logic),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_err    (out_err)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        case (op)
            3'd0: model = a + b;
            3'd1: model = a - b;
            3'd2: model = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: model = (a < b) ? 32'd1 : 32'd0;
            3'd4: model = a & b;
            3'd5: model = a | b;
            3'd6: model = a ^ b;
            default: model = ~(a | b);
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every outcome is compared in order (R2 R3 R4 R7 R8 R9).
    always @(negedge clk) begin
        if (rst_n && !finished && (out_valid || out_err)) begin
            if (head == tail) begin
                check("R4 unexpected commit", 1'b0, out_result, 32'h0);
            end else begin
                check("R4 commit cycle", cyc == sb_cyc[head % 64], cyc, sb_cyc[head % 64]);
                check("R7 R8 error flag", out_err == sb_err[head % 64], out_err, sb_err[head % 64]);
                check("R9 exclusive flags", !(out_valid && out_err), out_valid, 32'h0);
                if (sb_err[head % 64])
                    check("R7 result zeroed", out_result == 32'h0, out_result, 32'h0);
                else
                    check(sb_tag[head % 64] >= 4 ? "R3 logic result" : "R2 arith result",
                          out_result == sb_res[head % 64], out_result, sb_res[head % 64]);
                head++;
            end
        end
    end

    // Offer one instruction; a fault mask is applied only in its accept cycle.
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input bit dec_bad, input logic [31:0] fa, input logic [31:0] fl);
        in_valid = 1'b1;
        in_op_a  = op;
        in_op_b  = dec_bad ? (op ^ 3'b001) : op;
        in_src1  = a;
        in_src2  = b;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
        end
        flt_arith = fa;
        flt_logic = fl;
        sb_res[tail % 64] = model(op, a, b);
        sb_err[tail % 64] = dec_bad || (fa != 0) || (fl != 0);
        sb_cyc[tail % 64] = cyc + 5;
        sb_tag[tail % 64] = op;
        tail++;
        @(negedge clk);
        in_valid  = 1'b0;
        flt_arith = '0;
        flt_logic = '0;
    endtask

    task automatic drain(input string req);
        repeat (10) @(negedge clk);
        check(req, head == tail, head, tail);
    endtask

    task automatic t_reset;
        check("R1 out_valid low", out_valid == 1'b0, out_valid, 0);
        check("R1 out_err low", out_err == 1'b0, out_err, 0);
        check("R1 in_ready high", in_ready == 1'b1, in_ready, 1);
    endtask

    task automatic t_functions;
        issue(3'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        issue(3'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0);
        issue(3'd1, 32'h5, 32'h7, 0, 0, 0);
        issue(3'd5, 32'h1200_0000, 32'h0000_0034, 0, 0, 0);
        issue(3'd2, 32'h8000_0000, 32'h1, 0, 0, 0);
        issue(3'd6, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 0);
        issue(3'd3, 32'h8000_0000, 32'h1, 0, 0, 0);
        issue(3'd7, 32'h0F0F_0000, 32'h0000_00F0, 0, 0, 0);
        drain("R2 R3 all committed");
    endtask

    task automatic t_alternate;
        stalls = 0;
        for (int i = 0; i < 10; i++)
            issue((i % 2 == 0) ? 3'd1 : 3'd6, 32'h100 * i, 32'h33 + i, 0, 0, 0);
        check("R5 no stall in alternating stream", stalls == 0, stalls, 0);
        drain("R5 all committed");
    endtask

    task automatic t_same_class;
        stalls = 0;
        for (int i = 0; i < 6; i++)
            issue(3'd0, 32'h1000 + i, 32'h20 * i, 0, 0, 0);
        check("R6 intake paused", stalls > 0, stalls, 1);
        drain("R6 all committed");
    endtask

    task automatic t_faults;
        issue(3'd0, 32'h10, 32'h20, 0, 0, 0);
        issue(3'd5, 32'h1, 32'h2, 0, 0, 0);
        issue(3'd1, 32'h99, 32'h9, 0, 32'h0000_0100, 0);
        issue(3'd4, 32'hFF, 32'h0F, 0, 0, 0);
        issue(3'd6, 32'h3, 32'h5, 0, 0, 32'h8000_0000);
        issue(3'd0, 32'h7, 32'h8, 0, 0, 0);
        drain("R7 all committed");
    endtask

    task automatic t_decoder;
        issue(3'd4, 32'hC3, 32'h3C, 0, 0, 0);
        issue(3'd0, 32'h11, 32'h22, 1, 0, 0);
        issue(3'd2, 32'h3, 32'h4, 0, 0, 0);
        drain("R8 all committed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_functions();
        t_alternate();
        t_same_class();
        t_faults();
        t_decoder();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule